// File: doc/BRIEF.md
# Order-Ticket Collision Resolver

This unit sits beside one processor's cache controller. It settles ownership conflicts that arise while the processor is running a multi-update sequence. When the sequence opens, the unit takes a ticket from a global up-counter and announces it to every peer. Because the counter only moves upward, a lower ticket always means an earlier start. Each peer's announcement is compared with the local ticket. The result is kept as one bit per bus ID: the bit is 1 when that peer started later and so must give way. Every line loaded under the sequence is entered in a small set of collision-detect registers.

When a peer asks for ownership of one of those lines, the unit answers in one of two ways. If the peer started later, it refuses with a NAK, and the peer must abort. If the peer started earlier, the unit hands the line over and aborts its own sequence. Each peer that was refused is remembered. When the sequence ends, whether it finished or aborted, those peers receive a try-again message, one per cycle. An aborted unit keeps its ticket. It retries when a try-again arrives or when a programmable timeout expires, whichever is first. Keeping the ticket is what gives fair, first-come ordering across retries.

Top module: `otk_resolver`

## Requirements
- R1: After reset the unit is idle (`seq_active` = 0), every bit of `peer_later` is 0, and `resp_valid`, `abort_out`, `retry_out`, `bc_out_valid` and `ta_out_valid` are all 0.
- R2: A `seq_start` while idle has the following effects one cycle later: the unit is active, `ticket_in` has been captured as the unit's own ticket, `bc_out_valid` pulses with that ticket on `bc_out_ticket`, and every `peer_later` bit has been cleared.
- R3: During a sequence (active or waiting to retry), a peer broadcast sets `peer_later[bc_in_id]` to 1 exactly when `bc_in_ticket` is strictly greater than the own ticket. An equal or lower ticket writes 0. The vector is visible one cycle after the broadcast.
- R4: A `ld_valid` while active records `ld_addr` in the next free collision-detect slot. `NUM_CD` slots exist (default 4). Loads that arrive after every slot is filled are not recorded, and a later ownership request for such an address does not count as a conflict.
- R5: Every `rfo_valid` gets a response (`resp_valid` = 1) one cycle later. A request whose address is in no slot, or that arrives while the unit is not active, is answered with `resp_nak` = 0 and causes no abort, whatever the flags hold.
- R6: A conflicting request from a peer whose flag is 0 is answered with `resp_nak` = 0. In the same cycle `abort_out` pulses, the unit leaves the active state, and every slot is cleared.
- R7: A conflicting request from a peer whose flag is 1 is answered with `resp_nak` = 1. The sequence stays active and that bus ID is remembered.
- R8: When the sequence finishes (`seq_done`) or aborts, each bus ID refused during it is reported once on `ta_out_id` with `ta_out_valid`, one ID per cycle in ascending ID order. The first report comes two cycles after the cause.
- R9: A `nak_in` while active aborts the sequence: `abort_out` pulses one cycle later and the unit stops being active.
- R10: While waiting, a `ta_in` makes `retry_out` and `bc_out_valid` pulse one cycle later. The unit is active again and `bc_out_ticket` still carries the original ticket.
- R11: Without a `ta_in`, the retry happens by itself. `retry_out` rises `tmo_cycles`+1 cycles after the cycle in which `abort_out` went high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_cycles | input | TMO_W | Retry timeout while waiting for try-again |
| seq_start | input | 1 | Open a multi-update sequence |
| ticket_in | input | TICKET_W | Ticket read from the global up-counter |
| seq_done | input | 1 | Sequence completed successfully |
| ld_valid | input | 1 | A sequence load succeeded |
| ld_addr | input | ADDR_W | Line address of that load |
| bc_in_valid | input | 1 | Peer ticket broadcast received |
| bc_in_id | input | ID_W | Bus ID of the broadcasting peer |
| bc_in_ticket | input | TICKET_W | Peer's ticket |
| rfo_valid | input | 1 | Peer read-for-ownership snooped |
| rfo_id | input | ID_W | Bus ID of the requester |
| rfo_addr | input | ADDR_W | Requested line address |
| nak_in | input | 1 | Own ownership request was refused |
| ta_in | input | 1 | Try-again message received |
| resp_valid | output | 1 | Response to a snooped request |
| resp_nak | output | 1 | 1 = refuse (NAK), 0 = supply line |
| abort_out | output | 1 | Own sequence aborted |
| retry_out | output | 1 | Own sequence restarted with kept ticket |
| bc_out_valid | output | 1 | Broadcast own ticket to peers |
| bc_out_ticket | output | TICKET_W | Own ticket |
| ta_out_valid | output | 1 | Send try-again message |
| ta_out_id | output | ID_W | Destination bus ID of the try-again |
| seq_active | output | 1 | Sequence currently active |
| peer_later | output | NUM_IDS | Per-bus-ID flag: peer holds a later ticket |

## Verification
A snoop response, an abort, a retry triggered by try-again, a start broadcast and each flag update all show up one cycle after the input that causes them. The first try-again report comes two cycles after the finish or abort, because the refusal set is merged into a pending set before the serializer registers its output. A timed retry comes `tmo_cycles`+1 cycles after the abort pulse. The bench drives inputs on the falling edge and samples there too, so each single-step result is read exactly one edge after its cause. For the multi-cycle results, the bench counts falling edges and checks that the output is still low on every edge before the due one.

// File: rtl/otk_pkg.sv
package otk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_WAIT   = 2'd2
  } otk_state_e;
endpackage

// File: rtl/otk_flag_vec.sv
module otk_flag_vec #(
  parameter int NUM_IDS  = 16,
  parameter int ID_W     = $clog2(NUM_IDS),
  parameter int TICKET_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                in_seq,
  input  logic [TICKET_W-1:0] own_ticket,
  input  logic                bc_valid,
  input  logic [ID_W-1:0]     bc_id,
  input  logic [TICKET_W-1:0] bc_ticket,
  output logic [NUM_IDS-1:0]  flags
);
  logic later;
  assign later = in_seq && (bc_ticket > own_ticket);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
    end else if (bc_valid) begin
      flags[bc_id] <= later;
    end
  end

  // R3: a flag can only rise after a broadcast taken during a sequence
  assert_flag_needs_bcast_R3: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags)) != '0) |-> ($past(bc_valid) && $past(in_seq)));
endmodule

// File: rtl/otk_cd_regs.sv
module otk_cd_regs #(
  parameter int NUM_CD = 4,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              hit,
  output logic              full
);
  logic [NUM_CD-1:0] slot_v;
  logic [ADDR_W-1:0] slot_a [NUM_CD];
  logic [NUM_CD-1:0] wr_sel;
  logic [NUM_CD-1:0] match;

  // first free slot, one-hot
  always_comb begin
    wr_sel = '0;
    for (int i = 0; i < NUM_CD; i++) begin
      if (!slot_v[i] && (wr_sel == '0)) wr_sel[i] = 1'b1;
    end
  end

  assign full = &slot_v;

  generate
    for (genvar g = 0; g < NUM_CD; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          slot_v[g] <= 1'b0;
        end else if (ld_valid && wr_sel[g]) begin
          slot_v[g] <= 1'b1;
        end
      end
      always_ff @(posedge clk) begin
        if (ld_valid && wr_sel[g]) slot_a[g] <= ld_addr;
      end
      assign match[g] = slot_v[g] && (slot_a[g] == q_addr);
    end
  endgenerate

  assign hit = |match;

  // R4: an accepted load fills exactly one more slot
  assert_slot_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && $past(ld_valid) && !$past(full))
      |-> ($countones(slot_v) == $countones($past(slot_v)) + 1));
endmodule

// File: rtl/otk_notify.sv
module otk_notify #(
  parameter int NUM_IDS = 16,
  parameter int ID_W    = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nak_set,
  input  logic [ID_W-1:0]   nak_id,
  input  logic              release_now,
  output logic              ta_valid,
  output logic [ID_W-1:0]   ta_id
);
  logic [NUM_IDS-1:0] held, held_nx;
  logic [NUM_IDS-1:0] pending, pend_nx;
  logic               any;
  logic [ID_W-1:0]    sel;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any = 1'b1;
        sel = ID_W'(i);
      end
    end
    pend_nx = pending;
    if (any) pend_nx[sel] = 1'b0;
    held_nx = held;
    if (nak_set) held_nx[nak_id] = 1'b1;
    if (release_now) begin
      pend_nx = pend_nx | held_nx;
      held_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      pending  <= '0;
      ta_valid <= 1'b0;
      ta_id    <= '0;
    end else begin
      held     <= held_nx;
      pending  <= pend_nx;
      ta_valid <= any;
      ta_id    <= sel;
    end
  end

  // R8: every try-again goes to an ID that was waiting for one
  assert_ta_from_pending_R8: assert property (@(posedge clk) disable iff (rst)
    ta_valid |-> (($past(pending) & (NUM_IDS'(1) << ta_id)) != '0));
endmodule

// File: rtl/otk_resolver.sv
module otk_resolver
  import otk_pkg::*;
#(
  parameter int NUM_IDS  = 16,
  parameter int NUM_CD   = 4,
  parameter int TICKET_W = 64,
  parameter int ADDR_W   = 40,
  parameter int TMO_W    = 16,
  localparam int ID_W    = $clog2(NUM_IDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TMO_W-1:0]    tmo_cycles,
  input  logic                seq_start,
  input  logic [TICKET_W-1:0] ticket_in,
  input  logic                seq_done,
  input  logic                ld_valid,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic                bc_in_valid,
  input  logic [ID_W-1:0]     bc_in_id,
  input  logic [TICKET_W-1:0] bc_in_ticket,
  input  logic                rfo_valid,
  input  logic [ID_W-1:0]     rfo_id,
  input  logic [ADDR_W-1:0]   rfo_addr,
  input  logic                nak_in,
  input  logic                ta_in,
  output logic                resp_valid,
  output logic                resp_nak,
  output logic                abort_out,
  output logic                retry_out,
  output logic                bc_out_valid,
  output logic [TICKET_W-1:0] bc_out_ticket,
  output logic                ta_out_valid,
  output logic [ID_W-1:0]     ta_out_id,
  output logic                seq_active,
  output logic [NUM_IDS-1:0]  peer_later
);
  otk_state_e          state;
  logic [TICKET_W-1:0] own_ticket;
  logic [TMO_W-1:0]    wait_cnt;

  logic active, start_ok, cd_hit, cd_full, conflict, peer_wins;
  logic yield_now, nak_now, abort_now, finish_now, release_now, retry_now;

  assign active      = (state == ST_ACTIVE);
  assign start_ok    = seq_start && (state == ST_IDLE);
  assign conflict    = active && rfo_valid && cd_hit;
  assign peer_wins   = peer_later[rfo_id];
  assign yield_now   = conflict && !peer_wins;
  assign nak_now     = conflict && peer_wins;
  assign abort_now   = active && (yield_now || nak_in);
  assign finish_now  = active && seq_done && !abort_now;
  assign release_now = abort_now || finish_now;
  assign retry_now   = (state == ST_WAIT) && (ta_in || (wait_cnt == tmo_cycles));

  otk_flag_vec #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .TICKET_W(TICKET_W)) u_flags (
    .clk(clk), .rst(rst), .clr(start_ok), .in_seq(state != ST_IDLE),
    .own_ticket(own_ticket), .bc_valid(bc_in_valid), .bc_id(bc_in_id),
    .bc_ticket(bc_in_ticket), .flags(peer_later)
  );

  otk_cd_regs #(.NUM_CD(NUM_CD), .ADDR_W(ADDR_W)) u_cd (
    .clk(clk), .rst(rst), .clr(release_now || start_ok),
    .ld_valid(ld_valid && active), .ld_addr(ld_addr),
    .q_addr(rfo_addr), .hit(cd_hit), .full(cd_full)
  );

  otk_notify #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_notify (
    .clk(clk), .rst(rst), .nak_set(nak_now), .nak_id(rfo_id),
    .release_now(release_now), .ta_valid(ta_out_valid), .ta_id(ta_out_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      own_ticket   <= '0;
      wait_cnt     <= '0;
      resp_valid   <= 1'b0;
      resp_nak     <= 1'b0;
      abort_out    <= 1'b0;
      retry_out    <= 1'b0;
      bc_out_valid <= 1'b0;
    end else begin
      resp_valid   <= rfo_valid;
      resp_nak     <= nak_now;
      abort_out    <= abort_now;
      retry_out    <= retry_now;
      bc_out_valid <= start_ok || retry_now;
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            own_ticket <= ticket_in;
            state      <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (abort_now) begin
            state    <= ST_WAIT;
            wait_cnt <= '0;
          end else if (finish_now) begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (retry_now) begin
            state    <= ST_ACTIVE;
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign seq_active    = active;
  assign bc_out_ticket = own_ticket;

  // R5: responses only follow a snooped request
  assert_resp_after_rfo_R5: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(rfo_valid));
  // R7: refusing a peer never costs the own sequence
  assert_nak_keeps_seq_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_nak) |-> (!abort_out && state == ST_ACTIVE));
  // R6, R9: an abort always parks the unit in the waiting state
  assert_abort_waits_R6: assert property (@(posedge clk) disable iff (rst)
    abort_out |-> (state == ST_WAIT));
  // R10: a retry reuses the ticket and announces it
  assert_retry_keeps_ticket_R10: assert property (@(posedge clk) disable iff (rst)
    retry_out |-> ($stable(own_ticket) && bc_out_valid));
endmodule

// File: tb/otk_resolver_tb.sv
module otk_resolver_tb;
  localparam int NUM_IDS = 16, ID_W = 4, TW = 64, AW = 40, TMW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [TMW-1:0] tmo_cycles;
  logic seq_start, seq_done, ld_valid, bc_in_valid, rfo_valid, nak_in, ta_in;
  logic [TW-1:0] ticket_in, bc_in_ticket;
  logic [AW-1:0] ld_addr, rfo_addr;
  logic [ID_W-1:0] bc_in_id, rfo_id;
  logic resp_valid, resp_nak, abort_out, retry_out, bc_out_valid, ta_out_valid, seq_active;
  logic [TW-1:0] bc_out_ticket;
  logic [ID_W-1:0] ta_out_id;
  logic [NUM_IDS-1:0] peer_later;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  otk_resolver u_dut (
    .clk(clk), .rst(rst), .tmo_cycles(tmo_cycles), .seq_start(seq_start),
    .ticket_in(ticket_in), .seq_done(seq_done), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .bc_in_valid(bc_in_valid), .bc_in_id(bc_in_id), .bc_in_ticket(bc_in_ticket),
    .rfo_valid(rfo_valid), .rfo_id(rfo_id), .rfo_addr(rfo_addr), .nak_in(nak_in),
    .ta_in(ta_in), .resp_valid(resp_valid), .resp_nak(resp_nak), .abort_out(abort_out),
    .retry_out(retry_out), .bc_out_valid(bc_out_valid), .bc_out_ticket(bc_out_ticket),
    .ta_out_valid(ta_out_valid), .ta_out_id(ta_out_id), .seq_active(seq_active),
    .peer_later(peer_later)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    seq_start = 0; seq_done = 0; ld_valid = 0; bc_in_valid = 0;
    rfo_valid = 0; nak_in = 0; ta_in = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr_in();
  endtask

  task automatic bcast(input int id, input logic [63:0] t);
    bc_in_valid = 1; bc_in_id = ID_W'(id); bc_in_ticket = t; tick();
  endtask

  task automatic load(input logic [AW-1:0] a);
    ld_valid = 1; ld_addr = a; tick();
  endtask

  task automatic rfo(input int id, input logic [AW-1:0] a);
    rfo_valid = 1; rfo_id = ID_W'(id); rfo_addr = a; tick();
  endtask

  task automatic t_reset();
    chk("R1 active", seq_active, 0);
    chk("R1 flags", peer_later, 0);
    chk("R1 outs", {resp_valid, abort_out, retry_out, bc_out_valid, ta_out_valid}, 0);
  endtask

  task automatic t_start_flags();
    seq_start = 1; ticket_in = 64'd100; tick();
    chk("R2 active", seq_active, 1);
    chk("R2 bcast", bc_out_valid, 1);
    chk("R2 ticket", bc_out_ticket, 64'd100);
    bcast(3, 64'd200);  chk("R3 later", peer_later[3], 1);
    bcast(5, 64'd50);   chk("R3 earlier", peer_later[5], 0);
    bcast(7, 64'd100);  chk("R3 equal", peer_later[7], 0);
    bcast(9, 64'd300);  chk("R3 id9", peer_later[9], 1);
  endtask

  task automatic t_nak_finish();
    load(40'hA00);
    rfo(3, 40'hB00);
    chk("R5 miss resp", resp_valid, 1);
    chk("R5 miss supply", resp_nak, 0);
    chk("R5 miss no abort", abort_out, 0);
    rfo(9, 40'hA00);
    chk("R7 nak", resp_nak, 1);
    chk("R7 stays active", seq_active, 1);
    rfo(3, 40'hA00);
    chk("R7 nak id3", resp_nak, 1);
    seq_done = 1; tick();
    chk("R8 not yet", ta_out_valid, 0);
    chk("R8 idle", seq_active, 0);
    tick();
    chk("R8 first valid", ta_out_valid, 1);
    chk("R8 first id", ta_out_id, 3);
    tick();
    chk("R8 second valid", ta_out_valid, 1);
    chk("R8 second id", ta_out_id, 9);
    tick();
    chk("R8 drained", ta_out_valid, 0);
  endtask

  task automatic t_yield_timeout();
    seq_start = 1; ticket_in = 64'd400; tick();
    chk("R2 flags cleared", peer_later, 0);
    bcast(5, 64'd350);
    load(40'hC00);
    rfo(5, 40'hC00);
    chk("R6 supply", resp_nak, 0);
    chk("R6 abort", abort_out, 1);
    chk("R6 left active", seq_active, 0);
    rfo(5, 40'hC00);
    chk("R5 no abort while waiting", abort_out, 0);
    chk("R5 supply while waiting", resp_nak, 0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R11 early", retry_out, 0);
    end
    tick();
    chk("R11 retry", retry_out, 1);
    chk("R11 bcast", bc_out_valid, 1);
    chk("R10 kept ticket", bc_out_ticket, 64'd400);
    chk("R11 active", seq_active, 1);
  endtask

  task automatic t_capacity_abort();
    for (int i = 0; i < 5; i++) load(40'h100 + 40'(i));
    bcast(2, 64'd999);
    chk("R3 id2", peer_later[2], 1);
    rfo(2, 40'h103);
    chk("R4 recorded hit", resp_nak, 1);
    rfo(2, 40'h104);
    chk("R4 overflow not recorded", resp_nak, 0);
    chk("R4 overflow no abort", abort_out, 0);
    nak_in = 1; tick();
    chk("R9 abort", abort_out, 1);
    chk("R9 inactive", seq_active, 0);
    tick();
    chk("R8 abort notify", ta_out_valid, 1);
    chk("R8 abort id", ta_out_id, 2);
    ta_in = 1; tick();
    chk("R10 retry", retry_out, 1);
    chk("R10 bcast", bc_out_valid, 1);
    chk("R10 ticket", bc_out_ticket, 64'd400);
    seq_done = 1; tick();
    bcast(4, 64'd999);
    chk("R3 idle flag zero", peer_later[4], 0);
  endtask

  initial begin
    clr_in();
    rst = 1; tmo_cycles = 16'd5; ticket_in = '0; ld_addr = '0; rfo_addr = '0;
    bc_in_id = '0; bc_in_ticket = '0; rfo_id = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_start_flags();
    t_nak_finish();
    t_yield_timeout();
    t_capacity_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule